// File: doc/BRIEF.md
# Programmable Chip-Select Generator with Bus Stretching

This block sits beside the CPU on the external bus side of a chip. It watches the address bus and drives four chip-select pins: two I/O selects, one program-memory select and one general-purpose select. A small register file, loaded through a simple write port, holds the settings for each select:

- whether it is enabled;
- its active level;
- its address window;
- whether it asserts for the whole address-valid phase or only while E is high;
- a stretch of 0 to 3 cycles.

The two I/O windows always fill the upper part of the 4 KB block that holds the on-chip registers. That block moves with a base-nibble register. The general-purpose window is a base page plus a power-of-two size. The program window is either the upper half of the map or the whole map.

When windows overlap, one select wins. The I/O selects win first. The general-purpose select then beats the program select, unless a swap bit reverses that order. At the start of each access the winner's stretch count is loaded into a counter, and a stall output holds the CPU off until the counter runs out.

A select that is disabled, or any select outside expanded mode, drops its output enable so that the pin can serve as general-purpose I/O. All select outputs and enables are registered, so they change on clock edges in step with the bus.

Top module: `csGen`

## Requirements
- R1: After reset all four output enables are 0, `stall` is 0, `csOut` is 4'hF, every select is disabled and every stretch count is 0. Select index 0 is I/O select 1, index 1 is I/O select 2, index 2 is the program select and index 3 is the general-purpose select.
- R2: While `expandedMode` is 0, every `csOe` bit is 0 and no select is asserted, whatever the enable register holds.
- R3: I/O select 1 matches addresses whose top nibble equals the base nibble (register 5, bits [3:0]) and whose low 12 bits are in 0x060..0x7FF.
- R4: I/O select 2 matches addresses whose top nibble equals the base nibble and whose low 12 bits are in 0x800..0xFFF.
- R5: The program select is always active-low and qualified by address-valid only. It matches addresses 0x8000..0xFFFF, or every address when register 0 bit 5 is set.
- R6: The general-purpose select matches when addr[15:8+k] equals base[7:k]. The base is register 3 and k is register 4 bits [3:0], clamped to 8, so k=8 or more matches every address.
- R7: Among matching, enabled selects the order of precedence is I/O 1, I/O 2, general-purpose, program. Register 0 bit 4 places the program select ahead of the general-purpose select.
- R8: The active level of I/O 1, I/O 2 and the general-purpose select is high when register 1 bit 0, bit 1 or bit 2 respectively is set, and low otherwise. A select that is not asserted sits at the opposite level.
- R9: When the E qualifier bit is set (register 1 bit 4, 5 or 6 for I/O 1, I/O 2 and general-purpose), the winning select asserts only in cycles where `addrValid` and `eHigh` are both 1. When the bit is clear it asserts whenever `addrValid` is 1.
- R10: On the first cycle of `addrValid` after a low cycle, the stall counter loads the winner's 2-bit stretch count. Register 2 holds these counts: bits [1:0] for I/O 1, [3:2] for I/O 2, [5:4] for program and [7:6] for general-purpose. If no select wins it loads 0. `stall` is then high for exactly that many cycles, and never for a count of 0.
- R11: At most one select is asserted in any cycle. When nothing matches, or `addrValid` is 0, every select sits at its inactive level.
- R12: `csOut` and `csOe` reflect the inputs and registers of the previous clock cycle (one register stage).
- R13: Clearing a select's enable bit (register 0 bits [3:0], one per select index) drops its `csOe` bit. It also lets the next select in precedence take an overlapping address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| expandedMode | input | 1 | 1 when the chip runs with an external bus |
| addr | input | 16 | CPU address |
| addrValid | input | 1 | Address is valid this cycle |
| eHigh | input | 1 | E phase of the bus cycle |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register index (0..5) |
| cfgData | input | 8 | Register write data |
| csOut | output | 4 | Chip-select levels, index as in R1 |
| csOe | output | 4 | Chip-select output enables |
| stall | output | 1 | Holds off the CPU during stretch |

## Verification
The windows are probed at their edge addresses: 0x05F and 0x060, 0x7FF and 0x800, the page just outside the general-purpose block, and 0x7FFF against 0x8000. These probes separate off-by-one decodes from correct ones. A second set of probes moves the base nibble, the block size and the swap bit. It tells a fixed decode apart from one that follows the registers, and it shows whether precedence follows the swap bit. Accesses with E held low, then raised, separate the two timing qualifiers. Each stretch value from 0 to 3 is tried, which exposes counters that are off by one cycle or stall on 0. A long run of random addresses and settings, compared cycle by cycle with a behavioural model, catches interactions that the directed cases miss.

// File: rtl/csPkg.sv
package csPkg;
  parameter int ADDR_W    = 16;
  parameter int BLOCK_W   = 12;
  parameter int PAGE_W    = 8;
  parameter int NUM_SEL   = 4;
  parameter int STRETCH_W = 2;
  localparam int NIB_W    = ADDR_W - BLOCK_W;
  localparam int GBASE_W  = ADDR_W - PAGE_W;

  typedef struct packed {
    logic [NUM_SEL-1:0]           en;
    logic                         progFirst;
    logic                         progWhole;
    logic [2:0]                   actHigh;   // io1, io2, gen
    logic [2:0]                   qualE;     // io1, io2, gen
    logic [NUM_SEL*STRETCH_W-1:0] stretch;
    logic [GBASE_W-1:0]           genBase;
    logic [3:0]                   genSize;
    logic [NIB_W-1:0]             regNib;
  } csCfg_t;

  typedef struct packed {
    logic accStart;
    logic avPhase;
    logic ePhase;
  } csStrobe_t;
endpackage

// File: rtl/csCfgRegs.sv
module csCfgRegs
  import csPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic [2:0] cfgAddr,
  input  logic [7:0] cfgData,
  output csCfg_t     cfg
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (cfgWe) begin
      case (cfgAddr)
        3'd0: begin
          cfg.en        <= cfgData[NUM_SEL-1:0];
          cfg.progFirst <= cfgData[4];
          cfg.progWhole <= cfgData[5];
        end
        3'd1: begin
          cfg.actHigh <= cfgData[2:0];
          cfg.qualE   <= cfgData[6:4];
        end
        3'd2: cfg.stretch <= cfgData[NUM_SEL*STRETCH_W-1:0];
        3'd3: cfg.genBase <= cfgData[GBASE_W-1:0];
        3'd4: cfg.genSize <= cfgData[3:0];
        3'd5: cfg.regNib  <= cfgData[NIB_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/csDatapath.sv
module csDatapath
  import csPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 expandedMode,
  input  logic [ADDR_W-1:0]    addr,
  input  csCfg_t               cfg,
  input  csStrobe_t            strobe,
  output logic [NUM_SEL-1:0]   csOut,
  output logic [NUM_SEL-1:0]   csOe,
  output logic                 winValid,
  output logic [STRETCH_W-1:0] winStretch
);
  localparam int IO1_LO = 'h060;
  localparam int IO1_HI = 'h7FF;
  localparam int IO2_LO = 'h800;

  logic [NUM_SEL-1:0] hit, cand, enEff, actLevel, qualVec, nextOut;
  logic [1:0]         win;
  logic [BLOCK_W-1:0] offs;
  logic               inBlock, genHit, live;
  int                 kClamp;

  assign offs     = addr[BLOCK_W-1:0];
  assign inBlock  = (addr[ADDR_W-1:BLOCK_W] == cfg.regNib);
  assign actLevel = {cfg.actHigh[2], 1'b0, cfg.actHigh[1], cfg.actHigh[0]};
  assign qualVec  = {cfg.qualE[2], 1'b0, cfg.qualE[1], cfg.qualE[0]};
  assign enEff    = expandedMode ? cfg.en : '0;

  always_comb begin
    kClamp = (int'(cfg.genSize) > GBASE_W) ? GBASE_W : int'(cfg.genSize);
    genHit = 1'b1;
    for (int b = 0; b < GBASE_W; b++) begin
      if (b >= kClamp && addr[PAGE_W+b] != cfg.genBase[b]) genHit = 1'b0;
    end
  end

  assign hit[0] = inBlock && (int'(offs) >= IO1_LO) && (int'(offs) <= IO1_HI);
  assign hit[1] = inBlock && (int'(offs) >= IO2_LO);
  assign hit[2] = cfg.progWhole || addr[ADDR_W-1];
  assign hit[3] = genHit;
  assign cand   = hit & enEff;

  always_comb begin
    winValid = 1'b1;
    win      = 2'd0;
    if (cand[0])                      win = 2'd0;
    else if (cand[1])                 win = 2'd1;
    else if (cfg.progFirst && cand[2]) win = 2'd2;
    else if (cand[3])                 win = 2'd3;
    else if (cand[2])                 win = 2'd2;
    else                              winValid = 1'b0;
  end

  assign winStretch = cfg.stretch[win*STRETCH_W +: STRETCH_W];
  assign live = winValid && strobe.avPhase && (!qualVec[win] || strobe.ePhase);

  always_comb begin
    nextOut = ~actLevel;
    if (live) nextOut[win] = actLevel[win];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csOut <= '1;
      csOe  <= '0;
    end else begin
      csOut <= nextOut;
      csOe  <= enEff;
    end
  end
endmodule

// File: rtl/csCtrl.sv
module csCtrl
  import csPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 addrValid,
  input  logic                 eHigh,
  input  logic                 winValid,
  input  logic [STRETCH_W-1:0] winStretch,
  output csStrobe_t            strobe,
  output logic                 stall
);
  logic                 avPrev;
  logic [STRETCH_W-1:0] cnt;

  assign strobe.accStart = addrValid && !avPrev;
  assign strobe.avPhase  = addrValid;
  assign strobe.ePhase   = eHigh;
  assign stall           = (cnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      avPrev <= 1'b0;
      cnt    <= '0;
    end else begin
      avPrev <= addrValid;
      if (strobe.accStart)  cnt <= winValid ? winStretch : '0;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/csGen.sv
module csGen
  import csPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                expandedMode,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                addrValid,
  input  logic                eHigh,
  input  logic                cfgWe,
  input  logic [2:0]          cfgAddr,
  input  logic [7:0]          cfgData,
  output logic [NUM_SEL-1:0]  csOut,
  output logic [NUM_SEL-1:0]  csOe,
  output logic                stall
);
  csCfg_t               cfg;
  csStrobe_t            strobe;
  logic                 winValid;
  logic [STRETCH_W-1:0] winStretch;

  csCfgRegs u_regs (.clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
                    .cfgData(cfgData), .cfg(cfg));

  csDatapath u_dp (.clk(clk), .rstN(rstN), .expandedMode(expandedMode), .addr(addr),
                   .cfg(cfg), .strobe(strobe), .csOut(csOut), .csOe(csOe),
                   .winValid(winValid), .winStretch(winStretch));

  csCtrl u_ctrl (.clk(clk), .rstN(rstN), .addrValid(addrValid), .eHigh(eHigh),
                 .winValid(winValid), .winStretch(winStretch), .strobe(strobe),
                 .stall(stall));
endmodule

// File: rtl/csGenChecker.sv
module csGenChecker
  import csPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               expandedMode,
  input logic               addrValid,
  input logic [NUM_SEL-1:0] csOut,
  input logic [NUM_SEL-1:0] csOe,
  input logic               stall,
  input csCfg_t             cfg
);
  csCfg_t             cfgQ;
  logic               avPrevChk;
  logic [NUM_SEL-1:0] levelQ, assertedVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ      <= '0;
      avPrevChk <= 1'b0;
    end else begin
      cfgQ      <= cfg;
      avPrevChk <= addrValid;
    end
  end

  assign levelQ      = {cfgQ.actHigh[2], 1'b0, cfgQ.actHigh[1], cfgQ.actHigh[0]};
  assign assertedVec = csOe & ~(csOut ^ levelQ);

  // R11: never two selects asserted together
  p_one_select_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(assertedVec));

  // R11: idle bus leaves every select inactive
  p_idle_inactive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> (assertedVec == '0));

  // R2: single-chip mode releases every pin
  p_released_r2: assert property (@(posedge clk) disable iff (!rstN)
    !expandedMode |=> (csOe == '0));

  // R10: stall only begins right after an access start
  p_stall_from_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stall) |-> $past(addrValid && !avPrevChk));

  // R5: program select low only after an address-valid cycle
  p_prog_qual_r5: assert property (@(posedge clk) disable iff (!rstN)
    (csOe[2] && !csOut[2]) |-> $past(addrValid));
endmodule

bind csGen csGenChecker u_chk (.clk(clk), .rstN(rstN), .expandedMode(expandedMode),
  .addrValid(addrValid), .csOut(csOut), .csOe(csOe), .stall(stall), .cfg(cfg));

// File: tb/test_csGen.sv
`timescale 1ns/1ps
module test_csGen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        expandedMode = 1'b1;
  logic [15:0] addr = '0;
  logic        addrValid = 1'b0, eHigh = 1'b0, cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [7:0]  cfgData = '0;
  logic [3:0]  csOut, csOe;
  logic        stall;

  int vectors = 0, miscompares = 0;
  string curReq = "R1 reset";

  always #5 clk = ~clk;

  csGen i_csGen (.clk(clk), .rstN(rstN), .expandedMode(expandedMode), .addr(addr),
                 .addrValid(addrValid), .eHigh(eHigh), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
                 .cfgData(cfgData), .csOut(csOut), .csOe(csOe), .stall(stall));

  // behavioural reference model
  logic [7:0] mReg [6];
  logic [3:0] expOut, expOe;
  int         mCnt;
  bit         mAvPrev;

  function automatic bit mHit(int s, logic [15:0] a);
    int k;
    case (s)
      0: return (a[15:12] == mReg[5][3:0]) && (a[11:0] >= 12'h060) && (a[11:0] <= 12'h7FF);
      1: return (a[15:12] == mReg[5][3:0]) && (a[11:0] >= 12'h800);
      2: return mReg[0][5] || (a >= 16'h8000);
      default: begin
        k = (mReg[4][3:0] > 8) ? 8 : int'(mReg[4][3:0]);
        return (int'(a) >> (8 + k)) == ((int'(mReg[3]) << 8) >> (8 + k));
      end
    endcase
  endfunction

  function automatic bit mLevel(int s);
    case (s)
      0: return mReg[1][0];
      1: return mReg[1][1];
      2: return 1'b0;
      default: return mReg[1][2];
    endcase
  endfunction

  function automatic bit mQualE(int s);
    case (s)
      0: return mReg[1][4];
      1: return mReg[1][5];
      2: return 1'b0;
      default: return mReg[1][6];
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 6; i++) mReg[i] = 8'h00;
      expOut = 4'hF; expOe = 4'h0; mCnt = 0; mAvPrev = 0;
    end else begin
      int w;
      logic [3:0] en;
      int order [4];
      en = expandedMode ? mReg[0][3:0] : 4'h0;
      order = mReg[0][4] ? '{0, 1, 2, 3} : '{0, 1, 3, 2};
      w = -1;
      for (int i = 3; i >= 0; i--)
        if (en[order[i]] && mHit(order[i], addr)) w = order[i];
      for (int s = 0; s < 4; s++) expOut[s] = ~mLevel(s);
      if (w >= 0 && addrValid && (!mQualE(w) || eHigh)) expOut[w] = mLevel(w);
      expOe = en;
      if (addrValid && !mAvPrev) mCnt = (w >= 0) ? int'((mReg[2] >> (2 * w)) & 8'h3) : 0;
      else if (mCnt > 0) mCnt--;
      mAvPrev = addrValid;
      if (cfgWe && cfgAddr < 6) mReg[cfgAddr] = cfgData;
    end
  end

  task automatic compare();
    vectors++;
    if (csOut !== expOut || csOe !== expOe || stall !== (mCnt != 0)) begin
      miscompares++;
      $display("FAIL %s: act out=%h oe=%h stall=%b exp out=%h oe=%h stall=%b",
               curReq, csOut, csOe, stall, expOut, expOe, mCnt != 0);
    end
  endtask

  task automatic cyc(input logic [15:0] a, input bit av, input bit e);
    @(negedge clk);
    compare();
    addr = a; addrValid = av; eHigh = e; cfgWe = 1'b0;
  endtask

  task automatic wr(input int r, input logic [7:0] d);
    @(negedge clk);
    compare();
    addrValid = 1'b0; cfgWe = 1'b1; cfgAddr = 3'(r); cfgData = d;
  endtask

  task automatic acc(input logic [15:0] a);
    cyc(a, 1, 0); cyc(a, 1, 1); cyc(a, 1, 1); cyc(a, 0, 0);
    repeat (3) cyc(16'h0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1 reset state"; compare();
    rstN = 1'b1;
    cyc(16'h0, 0, 0); cyc(16'h2100, 1, 1); cyc(16'h0, 0, 0);

    curReq = "R2 single-chip release";
    wr(0, 8'h0F); wr(5, 8'h02); expandedMode = 1'b0;
    acc(16'h2100); acc(16'h9000); expandedMode = 1'b1;

    curReq = "R3 io1 window";
    wr(0, 8'h03);
    acc(16'h205F); acc(16'h2060); acc(16'h27FF); acc(16'h1060);
    curReq = "R4 io2 window";
    acc(16'h2800); acc(16'h2FFF); acc(16'h3800);
    wr(5, 8'h0A); acc(16'hA900); acc(16'h2900);

    curReq = "R8 polarity";
    wr(1, 8'h03); acc(16'hA100); acc(16'hA900);
    curReq = "R9 E qualifier";
    wr(1, 8'h31); acc(16'hA100); acc(16'hA900);
    wr(1, 8'h00);

    curReq = "R5 program select";
    wr(0, 8'h04); acc(16'h7FFF); acc(16'h8000); acc(16'hFFFF);
    wr(0, 8'h24); acc(16'h0000);

    curReq = "R6 general window";
    wr(0, 8'h08); wr(3, 8'h40); wr(4, 8'h02);
    acc(16'h3FFF); acc(16'h4000); acc(16'h43FF); acc(16'h4400);
    wr(1, 8'h44); acc(16'h4100); wr(1, 8'h00);
    wr(4, 8'h0C); acc(16'h1234);

    curReq = "R7 precedence";
    wr(3, 8'h90); wr(4, 8'h04); wr(0, 8'h0C); acc(16'h9000); acc(16'hA000);
    wr(0, 8'h1C); acc(16'h9000);
    wr(0, 8'h0F); wr(5, 8'h09); acc(16'h9100); acc(16'h9900);

    curReq = "R13 disable releases";
    wr(0, 8'h0E); acc(16'h9100); wr(0, 8'h06); acc(16'h9000);

    curReq = "R10 stretch";
    wr(0, 8'h0F);
    for (int s = 0; s < 4; s++) begin
      wr(2, 8'(s * 8'h55)); acc(16'h9100); acc(16'h9900); acc(16'h9000); acc(16'h5000);
    end

    curReq = "R11 R12 random traffic";
    for (int i = 0; i < 400; i++) begin
      if (i % 40 == 0) wr(int'($urandom_range(0, 5)), 8'($urandom));
      cyc(16'($urandom), 1'($urandom), 1'($urandom));
    end
    cyc(16'h0, 0, 0); cyc(16'h0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: act running exp finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule